// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Dot Engine

This block forms the signed dot product of two vectors held in block memory, one element pair per operation. Every operation runs through four two-cycle stages: fetch the pair, multiply it, fold the product into a running sum, and save. A start pulse latches a vector length and an issue mode. The engine then reads elements 0 to length-1 from two read ports in order, and writes the final sum once through a result write port, with a one-cycle done pulse alongside.

In the overlapped mode, the fetch and multiply of the next pair run while the current pair is still being added. Because each addition needs the sum left by the one before, a new operation starts every four cycles and no sooner. In the serial mode, each operation finishes all eight cycles before the next one starts. A higher layer that sequences rows and columns uses this engine as the inner product kernel of a matrix multiply.

Top module: `dot_mac_engine`

## Requirements
- R1: The written result equals the signed sum of a[i]*b[i] for i = 0 to length-1, where a and b are the words returned by the two read ports as 32-bit two's-complement values.
- R2: Both read ports present the same address, which runs 0, 1, ... length-1, each exactly once. The read enable is high in each cycle that carries an address, and the data arrive one cycle later.
- R3: With pipe_mode = 1, successive reads are 4 cycles apart. Done rises 8 + 4*(length-1) cycles after the cycle in which start was sampled. The first read comes in the cycle after start.
- R4: With pipe_mode = 0, successive reads are 8 cycles apart and done rises 8 + 8*(length-1) cycles after start.
- R5: Both modes give bit-identical results for the same vectors.
- R6: A length of 0 makes no reads. It writes the value 0 with done asserted one cycle after start.
- R7: The accumulator is cleared on each accepted start, so a job's result does not depend on earlier jobs.
- R8: Each job writes exactly once, and done is a one-cycle pulse that coincides with the write enable.
- R9: A start pulse that arrives while a job is running is ignored: it changes neither the result, the timing nor the number of writes.
- R10: The accumulator is 2*32 + log2(1024) = 74 bits wide. A sum of 1024 products of -2^31 by -2^31 (that is, 2^72) is written exactly, without wrap.
- R11: After reset, done, the write enable and both read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; sampled only while idle |
| pipe_mode | input | 1 | 1 = overlapped issue every 4 cycles, 0 = serial issue every 8 |
| vec_len | input | 11 | Number of element pairs, 0 to 1024 |
| a_rd_en | output | 1 | Read enable, first operand port |
| a_addr | output | 10 | Element index, first operand port |
| a_rdata | input | 32 | Signed word returned one cycle after the address |
| b_rd_en | output | 1 | Read enable, second operand port |
| b_addr | output | 10 | Element index, second operand port |
| b_rdata | input | 32 | Signed word returned one cycle after the address |
| res_wr_en | output | 1 | Result write strobe |
| res_wdata | output | 74 | Signed dot product |
| done | output | 1 | One-cycle job-complete pulse |

## Verification
The bench builds the engine with its defaults: 32-bit operands and a maximum length of 1024. This brings the full-length vector of extreme negative operands within reach, and so checks the 74-bit headroom exactly. Short and odd lengths, including lengths 0 and 1, run in both issue modes, so the issue spacing and the completion latency can be compared against 4 and 8 cycles per element. A start pulse injected in the middle of a job exercises the rule that starts are ignored while busy.

// File: rtl/dot_mac_pkg.sv
package dot_mac_pkg;
    localparam int STAGE_CYC = 2;
    localparam int N_STAGES  = 4;
    localparam int OP_LAT    = STAGE_CYC * N_STAGES;
    localparam int GAP_PIPE  = 4;
    localparam int GAP_SEQ   = OP_LAT;
    localparam int GAP_W     = $clog2(GAP_SEQ);

    typedef enum logic {
        ISSUE_SERIAL = 1'b0,
        ISSUE_OVERLAP = 1'b1
    } issue_mode_e;
endpackage

// File: rtl/dot_seq_ctrl.sv
module dot_seq_ctrl
    import dot_mac_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             job_done_i,
    output logic             busy_o,
    output logic             clr_o,
    output logic             issue_o,
    output logic             last_o,
    output logic [AW-1:0]    idx_o,
    output logic             zero_done_o
);
    typedef struct packed {
        logic             busy;
        logic             zero;
        issue_mode_e      mode;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] issued;
        logic [GAP_W-1:0] gap;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  clr_c, issue_c;

    always_comb begin
        ctl_d   = ctl_q;
        clr_c   = start_i && !ctl_q.busy;
        issue_c = ctl_q.busy && !ctl_q.zero && (ctl_q.issued < ctl_q.len) && (ctl_q.gap == '0);
        if (clr_c) begin
            ctl_d.busy   = 1'b1;
            ctl_d.zero   = (len_i == '0);
            ctl_d.mode   = issue_mode_e'(mode_i);
            ctl_d.len    = len_i;
            ctl_d.issued = '0;
            ctl_d.gap    = '0;
        end else if (ctl_q.busy) begin
            if (issue_c) begin
                ctl_d.issued = ctl_q.issued + 1'b1;
                ctl_d.gap    = (ctl_q.mode == ISSUE_OVERLAP) ? GAP_W'(GAP_PIPE - 1) : GAP_W'(GAP_SEQ - 1);
            end else if (ctl_q.gap != '0) begin
                ctl_d.gap = ctl_q.gap - 1'b1;
            end
            ctl_d.zero = 1'b0;
            if (job_done_i) ctl_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy_o      = ctl_q.busy;
    assign clr_o       = clr_c;
    assign issue_o     = issue_c;
    assign last_o      = issue_c && (ctl_q.issued == ctl_q.len - 1'b1);
    assign idx_o       = ctl_q.issued[AW-1:0];
    assign zero_done_o = ctl_q.zero;

    // R9: a start seen mid-job leaves the latched length untouched
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && start_i && !job_done_i) |=> (ctl_q.busy && $stable(ctl_q.len)));
endmodule

// File: rtl/dot_mac_pipe.sv
module dot_mac_pipe
    import dot_mac_pkg::*;
#(
    parameter int DW    = 32,
    parameter int ACC_W = 74
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             issue_i,
    input  logic             last_i,
    input  logic             zero_done_i,
    input  logic [DW-1:0]    a_rdata_i,
    input  logic [DW-1:0]    b_rdata_i,
    output logic             wr_en_o,
    output logic [ACC_W-1:0] wr_data_o
);
    localparam int PW   = 2 * DW;
    localparam int SLOT = OP_LAT - 1;

    typedef struct packed {
        logic [SLOT:1]    vld;
        logic [SLOT:1]    lst;
        logic [DW-1:0]    opa;
        logic [DW-1:0]    opb;
        logic [PW-1:0]    prod;
        logic [PW-1:0]    prod2;
        logic [ACC_W-1:0] sum;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] res;
    } pipe_t;

    pipe_t pp_d, pp_q;

    always_comb begin
        pp_d     = pp_q;
        pp_d.vld = {pp_q.vld[SLOT-1:1], issue_i};
        pp_d.lst = {pp_q.lst[SLOT-1:1], last_i};
        // load, second cycle: capture the returned words
        if (pp_q.vld[1]) begin
            pp_d.opa = a_rdata_i;
            pp_d.opb = b_rdata_i;
        end
        // multiply, two cycles
        if (pp_q.vld[2]) pp_d.prod  = PW'($signed(pp_q.opa) * $signed(pp_q.opb));
        if (pp_q.vld[3]) pp_d.prod2 = pp_q.prod;
        // add, two cycles: form the sum, then commit it
        if (pp_q.vld[4]) pp_d.sum = pp_q.acc + {{(ACC_W-PW){pp_q.prod2[PW-1]}}, pp_q.prod2};
        if (pp_q.vld[5]) pp_d.acc = pp_q.sum;
        // save, first cycle: hold the final sum for the write
        if (pp_q.vld[6] && pp_q.lst[6]) pp_d.res = pp_q.acc;
        if (clr_i) pp_d.acc = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign wr_en_o   = (pp_q.vld[SLOT] && pp_q.lst[SLOT]) || zero_done_i;
    assign wr_data_o = zero_done_i ? '0 : pp_q.res;

    // R3: ops enter no closer than four cycles, so fetch, multiply and add never hold two ops
    p_issue_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pp_q.vld[4:1]));
    // R7: an accepted start leaves a zero accumulator
    p_acc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pp_q.acc == '0));
    // R8: no two writes on consecutive cycles
    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/dot_mac_engine.sv
module dot_mac_engine
    import dot_mac_pkg::*;
#(
    parameter int DW      = 32,
    parameter int MAX_LEN = 1024,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int AW      = $clog2(MAX_LEN),
    parameter int ACC_W   = 2 * DW + $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pipe_mode,
    input  logic [LEN_W-1:0] vec_len,
    output logic             a_rd_en,
    output logic [AW-1:0]    a_addr,
    input  logic [DW-1:0]    a_rdata,
    output logic             b_rd_en,
    output logic [AW-1:0]    b_addr,
    input  logic [DW-1:0]    b_rdata,
    output logic             res_wr_en,
    output logic [ACC_W-1:0] res_wdata,
    output logic             done
);
    logic          busy_w, clr_w, issue_w, last_w, zero_w, wr_w;
    logic [AW-1:0] idx_w;

    dot_seq_ctrl #(.LEN_W(LEN_W), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .mode_i      (pipe_mode),
        .len_i       (vec_len),
        .job_done_i  (wr_w),
        .busy_o      (busy_w),
        .clr_o       (clr_w),
        .issue_o     (issue_w),
        .last_o      (last_w),
        .idx_o       (idx_w),
        .zero_done_o (zero_w)
    );

    dot_mac_pipe #(.DW(DW), .ACC_W(ACC_W)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_w),
        .issue_i     (issue_w),
        .last_i      (last_w),
        .zero_done_i (zero_w),
        .a_rdata_i   (a_rdata),
        .b_rdata_i   (b_rdata),
        .wr_en_o     (wr_w),
        .wr_data_o   (res_wdata)
    );

    assign a_rd_en   = issue_w;
    assign b_rd_en   = issue_w;
    assign a_addr    = idx_w;
    assign b_addr    = idx_w;
    assign res_wr_en = wr_w;
    assign done      = wr_w;

    // R8: a completion only happens inside a running job
    p_done_in_job_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_w);
    // R2: reads only while a job is running
    p_read_in_job_r2: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd_en |-> busy_w);
endmodule

// File: tb/dot_mac_engine_test.sv
module dot_mac_engine_test;
    localparam int DW = 32, MAXL = 1024, LW = 11, AW = 10, ACCW = 74;
    // stimulus table: {length, mode, pattern kind}
    localparam int NV = 11;
    localparam logic [13:0] VEC [0:NV-1] = '{
        {11'd1,    1'b1, 2'd0}, {11'd1,   1'b0, 2'd0}, {11'd2,  1'b1, 2'd1},
        {11'd5,    1'b0, 2'd3}, {11'd5,   1'b1, 2'd3}, {11'd16, 1'b1, 2'd1},
        {11'd33,   1'b0, 2'd3}, {11'd7,   1'b1, 2'd0}, {11'd100, 1'b1, 2'd3},
        {11'd1024, 1'b1, 2'd2}, {11'd1024, 1'b0, 2'd2}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0, pipe_mode = 1'b0;
    logic [LW-1:0] vec_len = '0;
    logic a_rd_en, b_rd_en, res_wr_en, done;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_rdata = '0, b_rdata = '0;
    logic [ACCW-1:0] res_wdata;

    dot_mac_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pipe_mode(pipe_mode), .vec_len(vec_len),
        .a_rd_en(a_rd_en), .a_addr(a_addr), .a_rdata(a_rdata),
        .b_rd_en(b_rd_en), .b_addr(b_addr), .b_rdata(b_rdata),
        .res_wr_en(res_wr_en), .res_wdata(res_wdata), .done(done)
    );

    logic signed [DW-1:0] mem_a [0:MAXL-1];
    logic signed [DW-1:0] mem_b [0:MAXL-1];
    always @(posedge clk) begin
        if (a_rd_en) a_rdata <= mem_a[a_addr];
        if (b_rd_en) b_rdata <= mem_b[b_addr];
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int n_reads, first_rd, last_rd, rd_err, gap_err, n_done, done_cyc, gap_exp;
    logic signed [ACCW-1:0] got;

    always @(negedge clk) begin
        if (a_rd_en) begin
            if (a_addr != AW'(n_reads) || b_addr != a_addr || !b_rd_en) rd_err++;
            if (n_reads > 0 && (cyc - last_rd) != gap_exp) gap_err++;
            if (n_reads == 0) first_rd = cyc;
            last_rd = cyc;
            n_reads++;
        end
        if (done) begin
            n_done++;
            done_cyc = cyc;
            got = res_wdata;
            if (!res_wr_en) rd_err++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic signed [ACCW-1:0] act, input logic signed [ACCW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] t = v;
        t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
        return t;
    endfunction

    task automatic fill(input int kind);
        logic [31:0] r = 32'h1234_5678 + 32'(kind);
        for (int i = 0; i < MAXL; i++) begin
            case (kind)
                0: begin mem_a[i] = 32'(i + 1); mem_b[i] = 32'(3 - i); end
                1: begin mem_a[i] = (i % 2) ? (32'sh8000_0000 + 32'(i)) : (32'sh7fff_ffff - 32'(i));
                         mem_b[i] = 32'(i * 7919 - 50000); end
                2: begin mem_a[i] = 32'sh8000_0000; mem_b[i] = 32'sh8000_0000; end
                default: begin r = xs(r); mem_a[i] = r; r = xs(r); mem_b[i] = r; end
            endcase
        end
    endtask

    function automatic logic signed [ACCW-1:0] ref_dot(input int len);
        logic signed [ACCW-1:0] s = '0;
        for (int i = 0; i < len; i++) s += $signed(mem_a[i]) * $signed(mem_b[i]);
        return s;
    endfunction

    // returns result and latency; poke > 0 pulses start again that many cycles into the job
    task automatic run_job(input int len, input logic mode, input int poke,
                           output logic signed [ACCW-1:0] res, output int lat, output int st);
        int w = 0;
        n_reads = 0; rd_err = 0; gap_err = 0; n_done = 0; first_rd = -1;
        gap_exp = mode ? 4 : 8;
        @(negedge clk); #1;
        start = 1'b1; vec_len = LW'(len); pipe_mode = mode; st = cyc;
        @(negedge clk); #1;
        start = 1'b0;
        while (n_done == 0 && w < 20000) begin
            if (poke > 0 && w == poke) begin
                start = 1'b1; vec_len = LW'(3); pipe_mode = ~mode;
            end else start = 1'b0;
            @(negedge clk); #1;
            w++;
        end
        start = 1'b0;
        if (n_done == 0) begin
            checks++; errors++;
            $display("FAIL watchdog actual=no-done expected=done");
        end
        repeat (12) begin @(negedge clk); #1; end
        res = got;
        lat = done_cyc - st;
    endtask

    initial begin
        logic signed [ACCW-1:0] r, e, r_ovl;
        int lat, st, len, kind;
        logic mode;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "done", ACCW'(done), 0);
        chk("R11", "wr_en", ACCW'(res_wr_en), 0);
        chk("R11", "rd_en", ACCW'(a_rd_en | b_rd_en), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            len = int'(VEC[v][13:3]); mode = VEC[v][2]; kind = int'(VEC[v][1:0]);
            fill(kind);
            e = ref_dot(len);
            run_job(len, mode, 0, r, lat, st);
            // R1 / R10 (full length extreme pattern) / R7 (prior job left no residue)
            chk(kind == 2 ? "R10" : "R1", "result", r, e);
            chk("R7", "result-after-previous-job", r, e);
            chk(mode ? "R3" : "R4", "latency", ACCW'(lat), ACCW'(8 + (mode ? 4 : 8) * (len - 1)));
            chk(mode ? "R3" : "R4", "issue-gap-errors", ACCW'(gap_err), 0);
            chk("R3", "first-read-cycle", ACCW'(first_rd - st), 1);
            chk("R2", "read-count", ACCW'(n_reads), ACCW'(len));
            chk("R2", "address-errors", ACCW'(rd_err), 0);
            chk("R8", "write-count", ACCW'(n_done), 1);
        end

        // R5: same vectors, both modes
        fill(3);
        run_job(77, 1'b1, 0, r_ovl, lat, st);
        run_job(77, 1'b0, 0, r, lat, st);
        chk("R5", "serial-vs-overlap", r, r_ovl);

        // R6: zero length in both modes
        for (int m = 0; m < 2; m++) begin
            run_job(0, m[0], 0, r, lat, st);
            chk("R6", "zero-result", r, 0);
            chk("R6", "zero-latency", ACCW'(lat), 1);
            chk("R6", "zero-reads", ACCW'(n_reads), 0);
        end

        // R9: start during a running job
        fill(0);
        e = ref_dot(10);
        run_job(10, 1'b1, 6, r, lat, st);
        chk("R9", "result", r, e);
        chk("R9", "latency", ACCW'(lat), ACCW'(8 + 4 * 9));
        chk("R9", "write-count", ACCW'(n_done), 1);
        chk("R9", "read-count", ACCW'(n_reads), 10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule